// File: doc/BRIEF.md
# Delta Pattern Prefetch Detector

The detector runs once for every new unique entry placed in an access history buffer. On a start pulse it captures the new line (frame) address. It then reads the history through an index/data port, newest entry first. It keeps only those entries that share the new address's 64 KB region, and it gathers up to sixteen region offsets, counting the trigger. It sorts the offsets so that loads issued out of order look ordered again, and takes the differences between neighbours.

Two tests then run on the difference list. The first is a periodic test: it looks for the recent run of deltas that repeats most deeply in the earlier history. The second looks for a stride that doubles each step. When either test succeeds, the detector emits candidate prefetch line addresses one per cycle, moving ahead of the highest address in the window. It stops at the limit for the mode that matched, or at the first candidate that would leave the region.

The controller is a state machine with six states.
- IDLE waits for `start` (transition START).
- GATHER reads one history entry per cycle. It leaves with GATHER_END when the history is exhausted or the window is full.
- SORT runs one odd-even transposition phase per cycle for as many cycles as the window holds. It leaves with SORT_END to SCAN, or with TOO_SHORT to DONE when the window holds fewer than four addresses.
- SCAN scores one candidate period per cycle. It leaves with SCAN_END to EMIT, or with NO_MATCH to DONE.
- EMIT issues one candidate per cycle. It leaves with LIMIT or LEAVE_REGION to DONE.
- DONE pulses `done` and returns to IDLE with FINISH.

Top module: `dpf_delta_detector`

## Requirements
- R1: Only history entries whose address bits above the low 10 equal those of the trigger address enter the window; other entries have no effect on the candidates.
- R2: The window holds the trigger plus at most the 15 newest matching history entries; older matching entries have no effect.
- R3: Window offsets are sorted ascending before deltas are taken. Candidates start from the largest address in the window and rise strictly.
- R4: With fewer than 3 deltas (fewer than 4 window addresses), no candidate is emitted and `done` still pulses.
- R5: Periodic mode. Let D be the delta count. For each period P from 1 to D-1, the score is the number of consecutive newest deltas that equal the delta P positions older. The best P is the highest score, with the smaller P winning a tie. A score of at least 2 matches. The candidates then replay the last P deltas cyclically, at most 4 of them.
- R6: A constant stride, and repeating cycles such as 1,2,1,2 or 1,2,3,4,1,2,3,4, are predicted in periodic mode.
- R7: Doubling mode. If every delta lies within plus or minus 1 of twice the delta before it, at most 2 candidates are emitted. The first step is twice the newest delta, and each further step doubles again.
- R8: When both modes match, periodic mode is used.
- R9: Emission stops at the first candidate whose region differs from the trigger's; that candidate and all later ones are not emitted.
- R10: `start` is taken only while idle. `busy` is high from the cycle after `start` through the `done` cycle. `done` is a single-cycle pulse, followed by idle. `pf_valid` is only ever high while busy.
- R11: After reset `busy`, `done` and `pf_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse: a new unique access was logged |
| trig_addr | input | AW | Line address of the new access |
| hist_len | input | HW+1 | Number of valid history entries |
| hist_idx | output | HW | History read index, 0 = newest |
| hist_addr | input | AW | History line address at `hist_idx`, same cycle |
| busy | output | 1 | Analysis in progress |
| done | output | 1 | One-cycle end-of-analysis pulse |
| pf_valid | output | 1 | Candidate strobe |
| pf_addr | output | AW | Candidate prefetch line address |

## Verification
The bench feeds addresses in scrambled order, so that a detector which skipped sorting would see negative steps and predict the wrong lines. It interleaves entries from other regions, and it buries out-of-pattern entries just beyond the sixteen-entry window. Either fault, a broken region filter or a missing cap, would move the base address or destroy the period. A stride of one also fits the doubling rule, so a design with the priority reversed would emit two doubling candidates instead of four unit steps. Patterns near the top of the region check that emission ends at the boundary and does not wrap into the next region. Short histories and an empty history check that the design finishes cleanly with no strobe.

// File: rtl/dpf_pkg.sv
package dpf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GATHER,
        ST_SORT,
        ST_SCAN,
        ST_EMIT,
        ST_DONE
    } dpf_state_e;

    typedef enum logic [1:0] {
        MODE_NONE,
        MODE_GEN,
        MODE_EXP
    } dpf_mode_e;
endpackage

// File: rtl/dpf_sort_phase.sv
// One odd-even transposition phase over the whole window.
module dpf_sort_phase #(
    parameter int N  = 16,
    parameter int KW = 11
) (
    input  logic [N-1:0][KW-1:0] keys_i,
    input  logic                 odd_i,
    output logic [N-1:0][KW-1:0] keys_o
);
    always_comb begin
        keys_o = keys_i;
        for (int i = 0; i < N - 1; i++) begin
            if ((i % 2) == int'(odd_i) && keys_i[i] > keys_i[i+1]) begin
                keys_o[i]   = keys_i[i+1];
                keys_o[i+1] = keys_i[i];
            end
        end
    end
endmodule

// File: rtl/dpf_period_score.sv
// Counts how many of the newest deltas repeat at distance per_i.
module dpf_period_score #(
    parameter int N  = 16,
    parameter int DW = 10,
    parameter int IW = 4
) (
    input  logic [N-1:0][DW-1:0] d_i,
    input  logic [IW-1:0]        nd_i,
    input  logic [IW-1:0]        per_i,
    output logic [IW-1:0]        len_o
);
    logic          run;
    logic [IW-1:0] ia;
    logic [IW-1:0] ib;

    always_comb begin
        run   = 1'b1;
        len_o = '0;
        ia    = '0;
        ib    = '0;
        for (int j = 0; j < N - 1; j++) begin
            if (run && (({1'b0, IW'(j)} + {1'b0, per_i}) < {1'b0, nd_i})) begin
                ia = nd_i - 1'b1 - IW'(j);
                ib = ia - per_i;
                if (d_i[ia] == d_i[ib]) len_o = len_o + 1'b1;
                else                    run   = 1'b0;
            end else begin
                run = 1'b0;
            end
        end
    end
endmodule

// File: rtl/dpf_exp_detect.sv
// True when every delta is within one of twice its predecessor.
module dpf_exp_detect #(
    parameter int N  = 16,
    parameter int DW = 10,
    parameter int IW = 4
) (
    input  logic [N-1:0][DW-1:0] d_i,
    input  logic [IW-1:0]        nd_i,
    output logic                 ok_o
);
    logic [DW:0] twice;
    logic [DW:0] cur;

    always_comb begin
        ok_o  = 1'b1;
        twice = '0;
        cur   = '0;
        for (int i = 1; i < N; i++) begin
            if (IW'(i) < nd_i) begin
                twice = {d_i[i-1], 1'b0};
                cur   = {1'b0, d_i[i]};
                if (!(cur == twice || cur + 1'b1 == twice || cur == twice + 1'b1))
                    ok_o = 1'b0;
            end
        end
    end
endmodule

// File: rtl/dpf_delta_detector.sv
module dpf_delta_detector
    import dpf_pkg::*;
#(
    parameter int AW        = 26,
    parameter int OW        = 10,
    parameter int WIN       = 16,
    parameter int HDEPTH    = 128,
    parameter int GEN_AHEAD = 4,
    parameter int EXP_AHEAD = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] trig_addr,
    input  logic [$clog2(HDEPTH):0]   hist_len,
    output logic [$clog2(HDEPTH)-1:0] hist_idx,
    input  logic [AW-1:0] hist_addr,
    output logic          busy,
    output logic          done,
    output logic          pf_valid,
    output logic [AW-1:0] pf_addr
);
    localparam int HW = $clog2(HDEPTH);
    localparam int IW = $clog2(WIN);
    localparam int KW = OW + 1;
    localparam int RW = AW - OW;
    localparam int KC = $clog2(GEN_AHEAD + 1);

    dpf_state_e state, state_nx;
    dpf_mode_e  mode;

    logic [RW-1:0]          region;
    logic [WIN-1:0][KW-1:0] keys, keys_nx;
    logic [WIN-1:0][OW-1:0] d;
    logic [IW:0]            n;
    logic [IW-1:0]          nd;
    logic [HW:0]            hidx;
    logic [IW-1:0]          cnt, per, best_len, best_per, ptr, score, fin_len, fin_per;
    logic [KC-1:0]          k;
    logic [AW:0]            cur, edelta, step;
    logic [AW+1:0]          nxt;
    logic                   exp_ok, better, in_reg, hit, gather_end, last;

    assign nd       = IW'(n - 1'b1);
    assign hist_idx = hidx[HW-1:0];
    assign hit      = (hist_addr[AW-1:OW] == region);
    assign gather_end = (hidx >= hist_len) || (hidx == (HW+1)'(HDEPTH)) || (n == (IW+1)'(WIN));

    always_comb begin
        for (int i = 0; i < WIN - 1; i++) d[i] = keys[i+1][OW-1:0] - keys[i][OW-1:0];
        d[WIN-1] = '0;
    end

    dpf_sort_phase #(.N(WIN), .KW(KW)) u_sort (
        .keys_i(keys), .odd_i(cnt[0]), .keys_o(keys_nx));

    dpf_period_score #(.N(WIN), .DW(OW), .IW(IW)) u_score (
        .d_i(d), .nd_i(nd), .per_i(per), .len_o(score));

    dpf_exp_detect #(.N(WIN), .DW(OW), .IW(IW)) u_exp (
        .d_i(d), .nd_i(nd), .ok_o(exp_ok));

    assign better  = score > best_len;
    assign fin_len = better ? score : best_len;
    assign fin_per = better ? per : best_per;

    assign step   = (mode == MODE_GEN) ? {{(AW+1-OW){1'b0}}, d[ptr]} : edelta;
    assign nxt    = {1'b0, cur} + {1'b0, step};
    assign in_reg = (nxt[AW+1:OW] == {2'b00, region});
    assign last   = (mode == MODE_GEN) ? (k == KC'(GEN_AHEAD - 1)) : (k == KC'(EXP_AHEAD - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_GATHER;
            ST_GATHER: if (gather_end) state_nx = ST_SORT;
            ST_SORT:   if (cnt == IW'(WIN - 1))
                           state_nx = (n < (IW+1)'(4)) ? ST_DONE : ST_SCAN;
            ST_SCAN:   if (per == nd - 1'b1)
                           state_nx = (fin_len >= IW'(2) || exp_ok) ? ST_EMIT : ST_DONE;
            ST_EMIT:   if (!in_reg || last) state_nx = ST_DONE;
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            region <= '0; keys <= '0; n <= '0; hidx <= '0; cnt <= '0;
            per <= '0; best_len <= '0; best_per <= '0; ptr <= '0;
            k <= '0; cur <= '0; edelta <= '0; mode <= MODE_NONE;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    region <= trig_addr[AW-1:OW];
                    for (int i = 0; i < WIN; i++) keys[i] <= {1'b1, {OW{1'b0}}};
                    keys[0] <= {1'b0, trig_addr[OW-1:0]};
                    n    <= (IW+1)'(1);
                    hidx <= '0;
                end
                ST_GATHER: begin
                    if (gather_end) begin
                        cnt <= '0;
                    end else begin
                        if (hit) begin
                            keys[n[IW-1:0]] <= {1'b0, hist_addr[OW-1:0]};
                            n <= n + 1'b1;
                        end
                        hidx <= hidx + 1'b1;
                    end
                end
                ST_SORT: begin
                    keys     <= keys_nx;
                    cnt      <= cnt + 1'b1;
                    per      <= IW'(1);
                    best_len <= '0;
                    best_per <= IW'(1);
                end
                ST_SCAN: begin
                    best_len <= fin_len;
                    best_per <= fin_per;
                    per      <= per + 1'b1;
                    mode     <= (fin_len >= IW'(2)) ? MODE_GEN : (exp_ok ? MODE_EXP : MODE_NONE);
                    ptr      <= nd - fin_per;
                    k        <= '0;
                    cur      <= {1'b0, region, keys[nd][OW-1:0]};
                    edelta   <= {{(AW-OW){1'b0}}, d[nd - 1'b1], 1'b0};
                end
                ST_EMIT: begin
                    cur    <= nxt[AW:0];
                    k      <= k + 1'b1;
                    ptr    <= (ptr == nd - 1'b1) ? nd - best_per : ptr + 1'b1;
                    edelta <= {edelta[AW-1:0], 1'b0};
                end
                ST_DONE: mode <= MODE_NONE;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy     = (state != ST_IDLE);
        done     = (state == ST_DONE);
        pf_valid = (state == ST_EMIT) && in_reg;
        pf_addr  = nxt[AW-1:0];
    end

    // Checks
    logic          keys_sorted;
    logic [KC-1:0] emit_cnt;

    always_comb begin
        keys_sorted = 1'b1;
        for (int i = 0; i < WIN - 1; i++)
            if (keys[i] > keys[i+1]) keys_sorted = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                emit_cnt <= '0;
        else if (start && !busy)   emit_cnt <= '0;
        else if (pf_valid)         emit_cnt <= emit_cnt + 1'b1;
    end

    AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy); // R10
    AST_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && $past(pf_valid) |-> pf_addr > $past(pf_addr)); // R3
    AST_SORTED: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SCAN |-> keys_sorted); // R3
    AST_EMIT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> emit_cnt < KC'(GEN_AHEAD)); // R5
endmodule

// File: tb/sim_dpf_delta_detector.sv
module sim_dpf_delta_detector;
    localparam int AW = 26;
    localparam int HW = 7;
    localparam int RG = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] trig_addr = '0;
    logic [HW:0]   hist_len = '0;
    logic [HW-1:0] hist_idx;
    logic [AW-1:0] hist_addr;
    logic          busy, done, pf_valid;
    logic [AW-1:0] pf_addr;

    logic [AW-1:0] hmem [128];
    assign hist_addr = hmem[hist_idx];

    always #2 clk = ~clk;

    dpf_delta_detector u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .trig_addr(trig_addr),
        .hist_len(hist_len), .hist_idx(hist_idx), .hist_addr(hist_addr),
        .busy(busy), .done(done), .pf_valid(pf_valid), .pf_addr(pf_addr));

    int total = 0;
    int bad   = 0;

    // fields: trig, nh, hist[8] newest first, ne, expected[4]  (offsets in region RG)
    localparam int VT [8][15] = '{
        '{  4, 6,   5,  6,  2,  3,  1,  0,  0, 0, 4,   7,   8,   9,  10},  // R3 R6 R8
        '{  9, 6,   7,  6,  4,  3,  1,  0,  0, 0, 4,  10,  12,  13,  15},  // R5 R6
        '{ 20, 8,  16, 13, 11, 10,  6,  3,  1, 0, 4,  21,  23,  26,  30},  // R5 R6
        '{ 97, 4,  45, 19,  6,  0,  0,  0,  0, 0, 2, 201, 409,   0,   0},  // R7
        '{ 10, 2,   5,  0,  0,  0,  0,  0,  0, 0, 0,   0,   0,   0,   0},  // R4
        '{ 20, 4,   6,  5,  1,  0,  0,  0,  0, 0, 0,   0,   0,   0,   0},  // R5 no match
        '{300, 4, 140, 60, 20,  0,  0,  0,  0, 0, 1, 620,   0,   0,   0},  // R9 R7
        '{920, 3, 820,720,620,  0,  0,  0,  0, 0, 1,1020,   0,   0,   0}   // R9 R5
    };

    logic [AW-1:0] exp_q [16];
    int            exp_n;
    logic [AW-1:0] got_q [16];
    int            got_n;

    function automatic logic [AW-1:0] ra(input int rg, input int off);
        return AW'((rg << 10) | off);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic run(input logic [AW-1:0] trig, input int nh, input string req);
        int wd;
        got_n = 0;
        hist_len = (HW+1)'(nh);
        @(negedge clk);
        start = 1'b1; trig_addr = trig;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R10", "busy after start", longint'(busy), 1);
        wd = 0;
        while (!done && wd < 1000) begin
            chk(!pf_valid || busy, "R10", "strobe outside busy", longint'(busy), 1);
            if (pf_valid && got_n < 16) begin got_q[got_n] = pf_addr; got_n++; end
            @(negedge clk);
            wd++;
        end
        chk(done == 1'b1, "R10", "done seen before watchdog", longint'(done), 1);
        @(negedge clk);
        chk(!done && !busy, "R10", "idle after done pulse", longint'({done, busy}), 0);
        chk(got_n == exp_n, req, "candidate count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++)
            chk(got_q[i] == exp_q[i], req, "candidate address", got_q[i], exp_q[i]);
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) hmem[i] = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !pf_valid, "R11", "reset outputs", longint'({busy, done, pf_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !pf_valid, "R11", "idle after reset", longint'({busy, done, pf_valid}), 0);

        // Table walk
        for (int v = 0; v < 8; v++) begin
            for (int i = 0; i < 8; i++) hmem[i] = ra(RG, VT[v][2+i]);
            exp_n = VT[v][10];
            for (int i = 0; i < 4; i++) exp_q[i] = ra(RG, VT[v][11+i]);
            run(ra(RG, VT[v][0]), VT[v][1], $sformatf("R5/vec%0d", v));
        end

        // R1: foreign-region entries interleaved
        hmem[0] = ra(RG, 5); hmem[1] = ra(6, 50); hmem[2] = ra(RG, 6); hmem[3] = ra(4, 9);
        hmem[4] = ra(RG, 2); hmem[5] = ra(RG, 3); hmem[6] = ra(RG, 1); hmem[7] = ra(RG, 0);
        exp_n = 4;
        for (int i = 0; i < 4; i++) exp_q[i] = ra(RG, 7 + i);
        run(ra(RG, 4), 8, "R1");

        // R2: entries beyond the window would break the stride
        for (int i = 0; i < 15; i++) hmem[i] = ra(RG, 38 - 2 * i);
        hmem[15] = ra(RG, 41); hmem[16] = ra(RG, 43);
        exp_n = 4;
        for (int i = 0; i < 4; i++) exp_q[i] = ra(RG, 42 + 2 * i);
        run(ra(RG, 40), 17, "R2");

        // R4: empty history
        exp_n = 0;
        run(ra(RG, 100), 0, "R4");

        // R10: start while busy is ignored (constant stride 3, restart pulse mid-run)
        hmem[0] = ra(RG, 9); hmem[1] = ra(RG, 6); hmem[2] = ra(RG, 3); hmem[3] = ra(RG, 0);
        hist_len = 8'd4;
        @(negedge clk);
        start = 1'b1; trig_addr = ra(RG, 12);
        @(negedge clk);
        trig_addr = ra(7, 500);
        @(negedge clk);
        start = 1'b0;
        got_n = 0;
        for (int w = 0; w < 1000 && !done; w++) begin
            if (pf_valid && got_n < 16) begin got_q[got_n] = pf_addr; got_n++; end
            @(negedge clk);
        end
        chk(got_n == 4, "R10", "count with extra start", got_n, 4);
        chk(got_q[0] == ra(RG, 15), "R10", "first candidate with extra start", got_q[0], ra(RG, 15));
        @(negedge clk);
        chk(!busy, "R10", "idle after run", longint'(busy), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule